// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block carries out single register reads and writes to an external physical-layer device. The device sits on an 18-bit address bus and a 32-bit data bus that are shared with a control-memory port. The host side offers a request made of an address, a direction bit and write data. The request is taken only while the block is idle and an external arbiter signals that the shared bus is free. The block then produces the device's chip-enable, read/write and output-enable strobes. The phases of these strobes are counted in clocks, and reads and writes use different windows. On a read, the block captures the word that the device returns. Every access ends with a one-clock completion pulse.

A second, independent path passes the device's active-low interrupt line through a two-flop synchroniser. The synchronised level is presented as an active-high status bit.

The sequencer has four states:
- `ST_IDLE`: no access. It moves to `ST_SETUP` when a request is accepted.
- `ST_SETUP`: address and direction are valid, chip enable is still high. It moves to `ST_ACTIVE` after `SETUP_CYC` clocks.
- `ST_ACTIVE`: chip enable is low. It moves to `ST_HOLD` after `WR_ACT_CYC` clocks for a write or `RD_ACT_CYC` clocks for a read.
- `ST_HOLD`: chip enable is high again, address and direction are still held. It returns to `ST_IDLE` after `HOLD_CYC` clocks, and that transition raises the completion pulse.

Top module: `phy_reg_seq`

## Requirements
- R1: After reset, `phy_ce_n`=1, `phy_oe_n`=1, `phy_rw`=0, `phy_wdata_oe`=0, `busy`=0, `done`=0 and `irq_status`=0.
- R2: A request is accepted only on a clock where `req_valid`=1, `bus_free`=1 and `busy`=0. While `bus_free`=0, no access starts: `busy` stays 0 and `phy_ce_n` stays 1.
- R3: `phy_addr` and `phy_rw` (1 = read, 0 = write) are valid one clock before `phy_ce_n` falls, and are held through the clock after it rises. `phy_addr` does not change while `busy`=1.
- R4: For a write, `phy_ce_n` is low for exactly 4 consecutive clocks, `phy_rw`=0 and `phy_oe_n` stays 1 for the whole access.
- R5: For a read, `phy_ce_n` is low for exactly 6 consecutive clocks and `phy_rw`=1. `phy_oe_n` is low on the 2nd to 5th of those clocks and high on the 1st and 6th, so it lies strictly inside the chip-enable window.
- R6: On a read, `rd_data` takes the value that `phy_rdata` has on the last clock with `phy_oe_n` low (the 5th chip-enable clock). `rd_data` keeps that value through any later writes until the next read completes.
- R7: `busy` is 1 from the clock after acceptance through the hold clock. `done` is a single-clock pulse on the clock after the hold clock: the 7th clock after acceptance for a write and the 9th for a read.
- R8: A request presented while `busy`=1 is ignored. The access in flight keeps its address and direction, and the ignored request is not performed afterwards.
- R9: `irq_status` is the inverse of `phy_irq_n`, delayed by two clock edges.
- R10: `phy_wdata_oe` is 1 only while `phy_ce_n` is low during a write, and `phy_wdata` then carries the request's write data. It is 0 during reads and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Device register address |
| req_wdata | input | 32 | Write data |
| bus_free | input | 1 | Arbiter: shared bus may be used |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Last captured read word |
| phy_addr | output | 18 | Shared address bus |
| phy_rw | output | 1 | Direction strobe, 1 = read |
| phy_ce_n | output | 1 | Device chip enable, active low |
| phy_oe_n | output | 1 | Device output enable, active low |
| phy_wdata | output | 32 | Data driven toward the shared bus |
| phy_wdata_oe | output | 1 | Data-bus drive enable |
| phy_rdata | input | 32 | Data returned from the shared bus |
| phy_irq_n | input | 1 | Device interrupt, active low |
| irq_status | output | 1 | Synchronised interrupt level |

## Verification
The hardest situation to reach from the ports is a competing request that arrives while an access is in flight. It must leave the address bus untouched and must not be replayed once the sequencer returns to idle. The stimulus holds `req_valid` high with a different address and direction on every busy clock, and drops it only on the clock the block is back in idle. It then checks that no second access begins. To show that capture happens on the right clock, the returned data word changes on every clock of a read, so sampling one clock early or late yields a different word. Seeded random accesses mix both directions, stalled grants and the competing-request pattern.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_HOLD   = 2'd3
    } acc_state_e;
endpackage

// File: rtl/phy_irq_sync.sv
module phy_irq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n_async,
    output logic irq_level
);
    logic meta_n, stable_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_n   <= 1'b1;
            stable_n <= 1'b1;
        end else begin
            meta_n   <= irq_n_async;
            stable_n <= meta_n;
        end
    end

    assign irq_level = ~stable_n;

    // R9: the status only rises after the first stage has seen the line low
    assert_irq_two_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_level) |-> $past(!meta_n));
endmodule

// File: rtl/phy_acc_fsm.sv
module phy_acc_fsm
    import phy_acc_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int HOLD_CYC   = 1,
    parameter int WR_ACT_CYC = 4,
    parameter int RD_ACT_CYC = 6,
    parameter int OE_DLY     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_write,
    output logic busy,
    output logic ce_n,
    output logic oe_n,
    output logic rd_dir,
    output logic drive_en,
    output logic sample_en,
    output logic done
);
    localparam int ACT_MAX = (WR_ACT_CYC > RD_ACT_CYC) ? WR_ACT_CYC : RD_ACT_CYC;
    localparam int EDGE_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int LEN_MAX = (ACT_MAX > EDGE_MAX) ? ACT_MAX : EDGE_MAX;
    localparam int CNT_W = $clog2(LEN_MAX + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(WR_ACT_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_ACT_CYC - 1);
    localparam logic [CNT_W-1:0] OE_FIRST   = CNT_W'(OE_DLY);
    localparam logic [CNT_W-1:0] OE_LAST    = CNT_W'(RD_ACT_CYC - 2);

    acc_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic phase_end;
    logic done_q;

    always_comb begin
        phase_end = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                phase_end = (cnt_q == SETUP_LAST);
                if (phase_end) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                phase_end = (cnt_q == (is_write ? WR_LAST : RD_LAST));
                if (phase_end) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                phase_end = (cnt_q == HOLD_LAST);
                if (phase_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            done_q  <= (state_q == ST_HOLD) && phase_end;
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        ce_n      = 1'b1;
        oe_n      = 1'b1;
        rd_dir    = 1'b0;
        drive_en  = 1'b0;
        sample_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP, ST_HOLD: rd_dir = !is_write;
            ST_ACTIVE: begin
                ce_n      = 1'b0;
                rd_dir    = !is_write;
                drive_en  = is_write;
                oe_n      = !(!is_write && cnt_q >= OE_FIRST && cnt_q <= OE_LAST);
                sample_en = !is_write && (cnt_q == OE_LAST);
            end
            default: ;
        endcase
    end

    assign done = done_q;

    // R3: chip enable falls only out of the setup phase
    assert_ce_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> $past(state_q == ST_SETUP));
    // R5: output enable low only inside the chip-enable window, never on its first clock
    assert_oe_inside_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!ce_n && $past(!ce_n) && rd_dir));
    // R10: data drive only during a write with chip enable low
    assert_drive_only_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!ce_n && !rd_dir && oe_n));
    // R7: completion is a single-clock pulse
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/phy_acc_dp.sv
module phy_acc_dp #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sample_en,
    input  logic              busy,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_data <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sample_en) rd_data <= phy_rdata;
        end
    end

    // R3 / R8: the address is frozen for the whole access
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq #(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 32,
    parameter int SETUP_CYC  = 1,
    parameter int HOLD_CYC   = 1,
    parameter int WR_ACT_CYC = 4,
    parameter int RD_ACT_CYC = 6,
    parameter int OE_DLY     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_free,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              phy_rw,
    output logic              phy_ce_n,
    output logic              phy_oe_n,
    output logic [DATA_W-1:0] phy_wdata,
    output logic              phy_wdata_oe,
    input  logic [DATA_W-1:0] phy_rdata,
    input  logic              phy_irq_n,
    output logic              irq_status
);
    logic accept, wr_q, sample_en;

    assign accept = req_valid && bus_free && !busy;

    phy_acc_fsm #(
        .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
        .WR_ACT_CYC(WR_ACT_CYC), .RD_ACT_CYC(RD_ACT_CYC), .OE_DLY(OE_DLY)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(accept), .is_write(wr_q),
        .busy(busy), .ce_n(phy_ce_n), .oe_n(phy_oe_n), .rd_dir(phy_rw),
        .drive_en(phy_wdata_oe), .sample_en(sample_en), .done(done)
    );

    phy_acc_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .sample_en(sample_en),
        .busy(busy), .phy_rdata(phy_rdata), .wr_q(wr_q), .addr_q(phy_addr),
        .wdata_q(phy_wdata), .rd_data(rd_data)
    );

    phy_irq_sync irq_i (
        .clk(clk), .rst_n(rst_n), .irq_n_async(phy_irq_n), .irq_level(irq_status)
    );
endmodule

// File: tb/phy_reg_seq_tb_top.sv
module phy_reg_seq_tb_top;
    localparam int WR_ACT = 4;
    localparam int RD_ACT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, bus_free = 1'b1, phy_irq_n = 1'b1;
    logic [17:0] req_addr = '0;
    logic [31:0] req_wdata = '0, phy_rdata = '0;
    logic busy, done, phy_rw, phy_ce_n, phy_oe_n, phy_wdata_oe, irq_status;
    logic [31:0] rd_data, phy_wdata;
    logic [17:0] phy_addr;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_rd = '0;

    always #4 clk = ~clk;

    phy_reg_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_free(bus_free),
        .busy(busy), .done(done), .rd_data(rd_data), .phy_addr(phy_addr),
        .phy_rw(phy_rw), .phy_ce_n(phy_ce_n), .phy_oe_n(phy_oe_n),
        .phy_wdata(phy_wdata), .phy_wdata_oe(phy_wdata_oe), .phy_rdata(phy_rdata),
        .phy_irq_n(phy_irq_n), .irq_status(irq_status)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rd_word(input logic [31:0] base, input int c);
        return base + c * 32'h0101_0101;
    endfunction

    // expected output enable for clock k of the chip-enable window (R5)
    function automatic logic exp_oe_n(input logic wr, input int k);
        if (wr) return 1'b1;
        return !(k >= 1 && k <= RD_ACT - 2);
    endfunction

    // One access, with stalled grant clocks and optional competing requests.
    task automatic access(input logic wr, input logic [17:0] a, input logic [31:0] d,
                          input int stall, input logic noise);
        int act;
        logic [31:0] base;
        act  = wr ? WR_ACT : RD_ACT;
        base = $urandom;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        bus_free = 1'b0;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R2 busy while bus not free", {31'd0, busy}, 32'd0);
            check("R2 ce_n while bus not free", {31'd0, phy_ce_n}, 32'd1);
        end
        bus_free = 1'b1;
        for (int c = 1; c <= act + 3; c++) begin
            @(negedge clk);
            if (noise && c <= act + 2) begin
                req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
            end else begin
                req_valid = 1'b0;
            end
            if (!wr) phy_rdata = rd_word(base, c);
            if (c <= act + 2) begin
                check("R7 busy during access", {31'd0, busy}, 32'd1);
                check("R3 R8 address held", {14'd0, phy_addr}, {14'd0, a});
                check("R3 R4 R5 direction", {31'd0, phy_rw}, {31'd0, ~wr});
                check("R7 done low mid-access", {31'd0, done}, 32'd0);
            end
            if (c == 1 || c == act + 2) begin
                check("R3 ce_n high in setup/hold", {31'd0, phy_ce_n}, 32'd1);
                check("R10 no drive in setup/hold", {31'd0, phy_wdata_oe}, 32'd0);
            end else if (c <= act + 1) begin
                check(wr ? "R4 ce_n low" : "R5 ce_n low", {31'd0, phy_ce_n}, 32'd0);
                check(wr ? "R4 oe_n" : "R5 oe_n", {31'd0, phy_oe_n},
                      {31'd0, exp_oe_n(wr, c - 2)});
                check("R10 drive enable", {31'd0, phy_wdata_oe}, {31'd0, wr});
                if (wr) check("R10 write data", phy_wdata, d);
            end
            if (c == act + 3) begin
                if (!wr) exp_rd = rd_word(base, act);
                check("R7 done pulse", {31'd0, done}, 32'd1);
                check("R7 busy released", {31'd0, busy}, 32'd0);
                check("R6 read data", rd_data, exp_rd);
                check("R1 rw idle level", {31'd0, phy_rw}, 32'd0);
            end
        end
        @(negedge clk);
        check("R7 done single", {31'd0, done}, 32'd0);
        check("R8 no replay busy", {31'd0, busy}, 32'd0);
        check("R8 no replay ce_n", {31'd0, phy_ce_n}, 32'd1);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 ce_n", {31'd0, phy_ce_n}, 32'd1);
        check("R1 oe_n", {31'd0, phy_oe_n}, 32'd1);
        check("R1 rw", {31'd0, phy_rw}, 32'd0);
        check("R1 wdata_oe", {31'd0, phy_wdata_oe}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 irq_status", {31'd0, irq_status}, 32'd0);
        rst_n = 1'b1;

        // directed corners
        access(1'b1, 18'h3FFFF, 32'hDEAD_BEEF, 0, 1'b0);
        access(1'b0, 18'h00000, 32'h0, 0, 1'b0);
        access(1'b1, 18'h15555, 32'h1234_5678, 3, 1'b1);   // R6: rd_data kept across write
        access(1'b0, 18'h2AAAA, 32'h0, 5, 1'b1);

        // R9 interrupt synchroniser
        @(negedge clk); phy_irq_n = 1'b0;
        @(negedge clk); check("R9 one edge", {31'd0, irq_status}, 32'd0);
        @(negedge clk); check("R9 two edges", {31'd0, irq_status}, 32'd1);
        @(negedge clk); phy_irq_n = 1'b1;
        check("R9 level held", {31'd0, irq_status}, 32'd1);
        @(negedge clk); check("R9 release one edge", {31'd0, irq_status}, 32'd1);
        @(negedge clk); check("R9 release two edges", {31'd0, irq_status}, 32'd0);

        // random mix
        for (int i = 0; i < 40; i++) begin
            access(1'($urandom), 18'($urandom), $urandom, int'($urandom % 4),
                   1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule